// File: doc/BRIEF.md
# Write-Guard and Status Unit for a Serial EEPROM

This unit sits beside the command decoder of a 512-byte serial EEPROM controller. It owns the write-enable latch, the two-bit protect field and the write-in-progress flag. The decoder sends it single-cycle events: the end of a write-enable command, the chip-select rising edge, a further clock bit, the write-disable command, a status-write request with its data byte, and an array-write request with its 9-bit address. It also receives pulses at the start and at the end of each self-timed write.

For every array or status write request, the unit answers one clock later with exactly one grant pulse or one deny pulse. The decoder commits the write only on a grant. A level input for the hardware lock pin vetoes every write.

The status byte is assembled from registers and can be shifted out unchanged by the serial logic.

Top module: `guard_status_unit`

## Requirements
- R1: After a synchronous reset, `status_out` is 0x00, `wel` and `wip` are 0, and no grant or deny pulse is asserted.
- R2: The write-enable latch is set only by a `cs_rise` pulse that arrives after a `wren_seen` pulse with no `extra_bit` pulse in between. An `extra_bit` pulse after `wren_seen` cancels the pending set. `wel` goes high in the cycle after `cs_rise`.
- R3: A `wrdi_cmd` pulse or a `wr_done` pulse clears `wel` in the following cycle.
- R4: Every `arr_req` gets exactly one of `arr_grant` or `arr_deny` in the next cycle. Every `sr_req` gets exactly one of `sr_grant` or `sr_deny` in the next cycle. A grant requires `wel`=1 at the time of the request.
- R5: The protect field codes are 00 = nothing protected, 01 = 0x180..0x1FF, 10 = 0x100..0x1FF, 11 = 0x000..0x1FF. An array request to a protected address is denied.
- R6: While `lock_pin` is 1, every array and status request is denied, and the protect field keeps its value.
- R7: A granted status write stores only bits 3:2 of `sr_data` as the protect field. Bits 7:4 of `status_out` always read 0.
- R8: Status bit 0 (WIP) reads 1 from the cycle after `wr_start` until the cycle after `wr_done`.
- R9: A denied request leaves `wel` and the protect field unchanged.
- R10: The status layout is bit 0 = WIP, bit 1 = WEL, bits 3:2 = protect field.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| lock_pin | input | 1 | Hardware write lock, active high |
| wren_seen | input | 1 | Pulse: eighth bit of a write-enable command received |
| cs_rise | input | 1 | Pulse: chip select went high |
| extra_bit | input | 1 | Pulse: another serial bit was clocked while selected |
| wrdi_cmd | input | 1 | Pulse: write-disable command decoded |
| sr_req | input | 1 | Pulse: status-write data byte complete |
| sr_data | input | 8 | Status-write data byte |
| arr_req | input | 1 | Pulse: array write ready to commit |
| arr_addr | input | 9 | Array write address |
| wr_start | input | 1 | Pulse: self-timed write started |
| wr_done | input | 1 | Pulse: self-timed write finished |
| arr_grant | output | 1 | Array write permitted |
| arr_deny | output | 1 | Array write rejected |
| sr_grant | output | 1 | Status write permitted |
| sr_deny | output | 1 | Status write rejected |
| status_out | output | 8 | Status byte for reads |
| wel | output | 1 | Write-enable latch |
| wip | output | 1 | Write in progress |

## Verification
The checker evaluates these properties on every cycle:
- each request receives a single response in the next cycle;
- no grant is issued without the latch set and the lock pin low;
- the latch rises only after a chip-select edge;
- the latch is cleared after a disable command or a write completion;
- the protect field changes only after a permitted status write;
- the busy bit follows the start and done pulses.

Some behaviours can only be shown by the bench's scenarios:
- an extra clock bit cancels a pending latch set;
- the address range of each protect code is correct at its boundaries;
- the stored field comes from bits 3:2 of the data byte.

The bench covers these with directed cases and a long random run against a model.

// File: rtl/gsu_pkg.sv
package gsu_pkg;
  typedef enum logic [1:0] {
    PROT_NONE = 2'b00,
    PROT_QTR  = 2'b01,
    PROT_HALF = 2'b10,
    PROT_ALL  = 2'b11
  } prot_e;

  localparam int unsigned SR_W      = 8;
  localparam int unsigned BIT_BUSY  = 0;
  localparam int unsigned BIT_WEL   = 1;
  localparam int unsigned FIELD_LO  = 2;
  localparam int unsigned FIELD_HI  = 3;
endpackage

// File: rtl/gsu_enable_latch.sv
module gsu_enable_latch (
  input  logic clk,
  input  logic rst,
  input  logic wren_seen,
  input  logic cs_rise,
  input  logic extra_bit,
  input  logic clear,
  output logic wel
);
  logic armed;

  // The set is pending only between the command end and the very next event.
  always_ff @(posedge clk) begin
    if (rst) begin
      armed <= 1'b0;
    end else if (wren_seen) begin
      armed <= 1'b1;
    end else if (cs_rise || extra_bit) begin
      armed <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wel <= 1'b0;
    end else if (clear) begin
      wel <= 1'b0;
    end else if (armed && cs_rise) begin
      wel <= 1'b1;
    end
  end
endmodule

// File: rtl/gsu_range_guard.sv
module gsu_range_guard #(
  parameter int unsigned ADDR_W = 9
) (
  input  gsu_pkg::prot_e   field,
  input  logic [ADDR_W-1:0] addr,
  output logic              hit
);
  import gsu_pkg::*;

  localparam int unsigned DEPTH   = 1 << ADDR_W;
  localparam int unsigned QTR_LO  = (DEPTH / 4) * 3;
  localparam int unsigned HALF_LO = DEPTH / 2;

  always_comb begin
    unique case (field)
      PROT_NONE: hit = 1'b0;
      PROT_QTR:  hit = ({1'b0, addr} >= (ADDR_W+1)'(QTR_LO));
      PROT_HALF: hit = ({1'b0, addr} >= (ADDR_W+1)'(HALF_LO));
      default:   hit = 1'b1;
    endcase
  end
endmodule

// File: rtl/gsu_busy_flag.sv
module gsu_busy_flag (
  input  logic clk,
  input  logic rst,
  input  logic wr_start,
  input  logic wr_done,
  output logic busy
);
  always_ff @(posedge clk) begin
    if (rst) begin
      busy <= 1'b0;
    end else if (wr_start) begin
      busy <= 1'b1;
    end else if (wr_done) begin
      busy <= 1'b0;
    end
  end
endmodule

// File: rtl/guard_status_unit.sv
module guard_status_unit #(
  parameter int unsigned ADDR_W = 9,
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              lock_pin,
  input  logic              wren_seen,
  input  logic              cs_rise,
  input  logic              extra_bit,
  input  logic              wrdi_cmd,
  input  logic              sr_req,
  input  logic [DATA_W-1:0] sr_data,
  input  logic              arr_req,
  input  logic [ADDR_W-1:0] arr_addr,
  input  logic              wr_start,
  input  logic              wr_done,
  output logic              arr_grant,
  output logic              arr_deny,
  output logic              sr_grant,
  output logic              sr_deny,
  output logic [DATA_W-1:0] status_out,
  output logic              wel,
  output logic              wip
);
  import gsu_pkg::*;

  prot_e field;
  logic  in_range;
  logic  arr_ok;
  logic  sr_ok;

  gsu_enable_latch u_latch (
    .clk       (clk),
    .rst       (rst),
    .wren_seen (wren_seen),
    .cs_rise   (cs_rise),
    .extra_bit (extra_bit),
    .clear     (wrdi_cmd || wr_done),
    .wel       (wel)
  );

  gsu_range_guard #(.ADDR_W(ADDR_W)) u_range (
    .field (field),
    .addr  (arr_addr),
    .hit   (in_range)
  );

  gsu_busy_flag u_busy (
    .clk      (clk),
    .rst      (rst),
    .wr_start (wr_start),
    .wr_done  (wr_done),
    .busy     (wip)
  );

  assign arr_ok = wel && !lock_pin && !in_range;
  assign sr_ok  = wel && !lock_pin;

  always_ff @(posedge clk) begin
    if (rst) begin
      arr_grant <= 1'b0;
      arr_deny  <= 1'b0;
      sr_grant  <= 1'b0;
      sr_deny   <= 1'b0;
      field     <= PROT_NONE;
    end else begin
      arr_grant <= arr_req && arr_ok;
      arr_deny  <= arr_req && !arr_ok;
      sr_grant  <= sr_req && sr_ok;
      sr_deny   <= sr_req && !sr_ok;
      if (sr_req && sr_ok) begin
        field <= prot_e'(sr_data[FIELD_HI:FIELD_LO]);
      end
    end
  end

  always_comb begin
    status_out = '0;
    status_out[BIT_BUSY] = wip;
    status_out[BIT_WEL]  = wel;
    status_out[FIELD_HI:FIELD_LO] = field;
  end
endmodule

// File: rtl/gsu_checker.sv
module gsu_checker #(
  parameter int unsigned ADDR_W = 9,
  parameter int unsigned DATA_W = 8
) (
  input logic              clk,
  input logic              rst,
  input logic              lock_pin,
  input logic              cs_rise,
  input logic              wrdi_cmd,
  input logic              sr_req,
  input logic              arr_req,
  input logic              wr_start,
  input logic              wr_done,
  input logic              arr_grant,
  input logic              arr_deny,
  input logic              sr_grant,
  input logic              sr_deny,
  input logic [DATA_W-1:0] status_out,
  input logic              wel
);
  assert_wel_source_R2: assert property (@(posedge clk) disable iff (rst)
    ($rose(wel) && !$past(rst)) |-> $past(cs_rise));

  assert_wel_clear_R3: assert property (@(posedge clk) disable iff (rst)
    (wrdi_cmd || wr_done) |=> !wel);

  assert_arr_answer_R4: assert property (@(posedge clk) disable iff (rst)
    arr_req |=> (arr_grant != arr_deny));

  assert_sr_answer_R4: assert property (@(posedge clk) disable iff (rst)
    sr_req |=> (sr_grant != sr_deny));

  assert_grant_needs_wel_R4: assert property (@(posedge clk) disable iff (rst)
    (arr_grant || sr_grant) |-> $past(wel));

  assert_lock_veto_R6: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(lock_pin)) |-> !(arr_grant || sr_grant));

  assert_field_change_R7: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && !$stable(status_out[3:2])) |->
      $past(sr_req && wel && !lock_pin));

  assert_busy_set_R8: assert property (@(posedge clk) disable iff (rst)
    wr_start |=> status_out[0]);

  assert_busy_clear_R8: assert property (@(posedge clk) disable iff (rst)
    (wr_done && !wr_start) |=> !status_out[0]);
endmodule

bind guard_status_unit gsu_checker #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
  .clk        (clk),
  .rst        (rst),
  .lock_pin   (lock_pin),
  .cs_rise    (cs_rise),
  .wrdi_cmd   (wrdi_cmd),
  .sr_req     (sr_req),
  .arr_req    (arr_req),
  .wr_start   (wr_start),
  .wr_done    (wr_done),
  .arr_grant  (arr_grant),
  .arr_deny   (arr_deny),
  .sr_grant   (sr_grant),
  .sr_deny    (sr_deny),
  .status_out (status_out),
  .wel        (wel)
);

// File: tb/sim_guard_status_unit.sv
module sim_guard_status_unit;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       lock_pin = 1'b0;
  logic       wren_seen = 1'b0, cs_rise = 1'b0, extra_bit = 1'b0, wrdi_cmd = 1'b0;
  logic       sr_req = 1'b0, arr_req = 1'b0, wr_start = 1'b0, wr_done = 1'b0;
  logic [7:0] sr_data = '0;
  logic [8:0] arr_addr = '0;
  logic       arr_grant, arr_deny, sr_grant, sr_deny, wel, wip;
  logic [7:0] status_out;

  int checks = 0;
  int fails  = 0;
  bit over   = 0;

  // Reference model state.
  bit       m_wel, m_wip, m_armed;
  bit [1:0] m_field;

  localparam int OP_WREN = 0, OP_CS = 1, OP_BIT = 2, OP_WRDI = 3,
                 OP_SR = 4, OP_ARR = 5, OP_START = 6, OP_DONE = 7;

  always #10 clk = ~clk;

  guard_status_unit u0 (.*);

  function automatic bit prot_hit(bit [1:0] f, bit [8:0] a);
    case (f)
      2'b00:   return 1'b0;
      2'b01:   return a >= 9'h180;
      2'b10:   return a >= 9'h100;
      default: return 1'b1;
    endcase
  endfunction

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic do_op(int op, bit [8:0] a, bit [7:0] d, string tag);
    bit eg_a = 0, ed_a = 0, eg_s = 0, ed_s = 0;
    unique case (op)
      OP_WREN:  wren_seen = 1'b1;
      OP_CS:    cs_rise   = 1'b1;
      OP_BIT:   extra_bit = 1'b1;
      OP_WRDI:  wrdi_cmd  = 1'b1;
      OP_SR:    begin sr_req  = 1'b1; sr_data  = d; end
      OP_ARR:   begin arr_req = 1'b1; arr_addr = a; end
      OP_START: wr_start  = 1'b1;
      default:  wr_done   = 1'b1;
    endcase
    // Model update from the state before the edge.
    unique case (op)
      OP_WREN:  m_armed = 1;
      OP_CS:    begin if (m_armed) m_wel = 1; m_armed = 0; end
      OP_BIT:   m_armed = 0;
      OP_WRDI:  m_wel = 0;
      OP_SR:    begin
                  eg_s = m_wel && !lock_pin; ed_s = !eg_s;
                  if (eg_s) m_field = d[3:2];
                end
      OP_ARR:   begin
                  eg_a = m_wel && !lock_pin && !prot_hit(m_field, a);
                  ed_a = !eg_a;
                end
      OP_START: m_wip = 1;
      default:  begin m_wip = 0; m_wel = 0; end
    endcase
    @(posedge clk);
    @(negedge clk);
    {wren_seen, cs_rise, extra_bit, wrdi_cmd, sr_req, arr_req, wr_start, wr_done} = '0;
    check({tag, " R4 array response"}, {arr_grant, arr_deny}, {eg_a, ed_a});
    check({tag, " R4 status response"}, {sr_grant, sr_deny}, {eg_s, ed_s});
    check({tag, " R10 status byte"}, status_out, {4'b0, m_field, m_wel, m_wip});
  endtask

  initial begin
    int unsigned seed = 32'd2024;
    void'($urandom(seed));
    m_wel = 0; m_wip = 0; m_armed = 0; m_field = 0;
    repeat (4) @(negedge clk);
    rst = 1'b0;
    check("R1 reset status", status_out, 8'h00);
    check("R1 reset outputs", {arr_grant, arr_deny, sr_grant, sr_deny, wel, wip}, 6'b0);

    // R2: an extra bit cancels the pending set.
    do_op(OP_WREN, 0, 0, "R2");
    do_op(OP_BIT, 0, 0, "R2");
    do_op(OP_CS, 0, 0, "R2");
    check("R2 cancelled wel", wel, 1'b0);
    // R9: denied array write without the latch leaves state alone.
    do_op(OP_ARR, 9'h010, 0, "R9");
    check("R9 wel after deny", wel, 1'b0);
    do_op(OP_WREN, 0, 0, "R2");
    do_op(OP_CS, 0, 0, "R2");
    check("R2 wel set", wel, 1'b1);
    // R7: only bits 3:2 are stored.
    do_op(OP_SR, 0, 8'hF7, "R7");
    check("R7 status after write", status_out, 8'h06);
    // R5 boundaries for code 01.
    do_op(OP_ARR, 9'h17F, 0, "R5");
    do_op(OP_ARR, 9'h180, 0, "R5");
    // R6: lock pin blocks, field kept.
    lock_pin = 1'b1;
    do_op(OP_SR, 0, 8'h0C, "R6");
    check("R6 field kept", status_out[3:2], 2'b01);
    do_op(OP_ARR, 9'h000, 0, "R6");
    lock_pin = 1'b0;
    // R8 then R3 via write completion.
    do_op(OP_START, 0, 0, "R8");
    check("R8 busy high", status_out[0], 1'b1);
    do_op(OP_DONE, 0, 0, "R3");
    check("R3 wel cleared by done", wel, 1'b0);
    do_op(OP_WREN, 0, 0, "R2");
    do_op(OP_CS, 0, 0, "R2");
    do_op(OP_WRDI, 0, 0, "R3");
    check("R3 wel cleared by disable", wel, 1'b0);

    for (int i = 0; i < 4000; i++) begin
      int op = int'($urandom_range(0, 7));
      if (op == OP_START && m_wip) op = OP_DONE;
      lock_pin = ($urandom_range(0, 5) == 0);
      do_op(op, 9'($urandom), 8'($urandom), "rand");
    end

    if (!over) begin
      over = 1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!over) begin
      over = 1;
      checks++;
      fails++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule